// File: doc/BRIEF.md
# Permutation-Routed Triplicated Pipeline

This block is a fixed-depth arithmetic pipeline in which every stage is present three times, once for each redundant instance. A permutation switch sits behind each stage. It takes the three registered stage results and hands them on to the three lanes of the next stage, or to the outputs after the last stage, in any of the six one-to-one orders. Each stage has its own 3-bit routing code, so the path of every instance can be assembled from whichever stage copies are healthy. No fabric reconfiguration is needed: the switches are plain multiplexers, and a new routing takes effect as soon as it is captured.

Each stage copy computes a single multiply-accumulate tap. The pipeline carries one valid bit next to the data. When the routing vector changes, the new vector is captured at the next sample slot and every sample already past the first stage is discarded, so that no result ever mixes two routings. For test, every stage copy has a pair of stuck-at controls that force its output to all ones or all zeros. This makes it possible to exercise the routing with known-bad copies. The three instance results leave the block together, qualified by one output valid.

Top module: `tri_perm_pipe`

## Requirements
- R1: Copy j of stage s registers y = (x * MUL + (s+1) * ADD) mod 2^W, where x is the routed lane j value from stage s-1. All three copies of stage 0 take in_sample. A sample accepted at one edge appears at the outputs after NSTAGE edges.
- R2: The switch behind stage s drives its lane j from stage copy src(code, j). With the sources for lanes 0,1,2 listed in that order, the codes are: 0 → (0,1,2), 1 → (1,0,2), 2 → (0,2,1), 3 → (2,1,0), 4 → (1,2,0), 5 → (2,0,1).
- R3: Routing codes 6 and 7 behave exactly like code 0.
- R4: The routing code of stage s occupies cfg_in bits [3s+2:3s]. The switch behind the last stage drives out_inst0, out_inst1 and out_inst2 as its lanes 0, 1 and 2.
- R5: At an edge where cfg_in differs from the captured routing, the new routing is captured and every in-flight sample beyond stage 0 is invalidated. A sample accepted at that same edge is routed entirely under the new vector.
- R6: While the routing is unchanged, the valid bit moves one stage per edge. out_valid is the in_valid that was accepted NSTAGE edges earlier.
- R7: stuck_hi bit 3s+j forces the output of copy j of stage s to all ones. stuck_lo bit 3s+j forces it to all zeros. When both are set, all ones wins.
- R8: When no stuck-at control has been active while a sample travelled through the pipeline, the three instance results for that sample are equal under every routing vector.
- R9: During reset and after it, out_valid stays low until a sample accepted after reset reaches the end. The captured routing resets to all-identity.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_sample carries a sample this cycle |
| in_sample | input | W | Sample fed to all three stage-0 copies |
| cfg_in | input | 3*NSTAGE | Routing vector, one 3-bit code per stage |
| stuck_hi | input | 3*NSTAGE | Test control: force copy output to all ones |
| stuck_lo | input | 3*NSTAGE | Test control: force copy output to all zeros |
| out_valid | output | 1 | The three instance results are valid |
| out_inst0 | output | W | Result of instance 0 |
| out_inst1 | output | W | Result of instance 1 |
| out_inst2 | output | W | Result of instance 2 |

## Verification
A change of the routing vector and the acceptance of a new sample can occur at the same edge. This is the one case in which a flush and a fill overlap. The bench provokes it by streaming samples under one vector and then switching to another while in_valid stays high. The pass criteria are an output gap of exactly NSTAGE-1 invalid cycles, after which the first valid result must match the arithmetic model under the new vector only. An exhaustive sweep of every routing vector is also run, each vector paired with stuck-at faults on different copies, so that the three lanes differ and each permutation shows up at the outputs.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int unsigned LANES  = 3;
  localparam int unsigned CODE_W = 3;

  typedef logic [CODE_W-1:0] route_code_t;
  typedef logic [1:0]        lane_sel_t;

  // packed source map: lane j source copy in bits [2j+1:2j]
  function automatic logic [5:0] route_map(input route_code_t code);
    case (code)
      3'd1:    route_map = {2'd2, 2'd0, 2'd1};
      3'd2:    route_map = {2'd1, 2'd2, 2'd0};
      3'd3:    route_map = {2'd0, 2'd1, 2'd2};
      3'd4:    route_map = {2'd0, 2'd2, 2'd1};
      3'd5:    route_map = {2'd1, 2'd0, 2'd2};
      default: route_map = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  function automatic lane_sel_t route_src(input route_code_t code, input int unsigned lane);
    logic [5:0] m;
    m = route_map(code);
    route_src = m[2*lane +: 2];
  endfunction
endpackage

// File: rtl/tpp_copy.sv
module tpp_copy #(
  parameter int unsigned W     = 16,
  parameter int unsigned STAGE = 0,
  parameter int unsigned MUL   = 3,
  parameter int unsigned ADD   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         force_hi,
  input  logic         force_lo,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] K_MUL = W'(MUL);
  localparam logic [W-1:0] K_OFF = W'((STAGE + 1) * ADD);

  function automatic logic [W-1:0] tap_eval(input logic [W-1:0] x);
    tap_eval = (x * K_MUL) + K_OFF;
  endfunction

  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= tap_eval(din);
  end

  // test-only stuck-at override, ones dominate
  always_comb begin
    if (force_hi)      dout = '1;
    else if (force_lo) dout = '0;
    else               dout = q;
  end
endmodule

// File: rtl/tpp_router.sv
module tpp_router
  import tpp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [LANES*W-1:0] lanes_in,
  input  route_code_t        code,
  output logic [LANES*W-1:0] lanes_out
);
  function automatic logic [W-1:0] pick(input logic [LANES*W-1:0] bus, input lane_sel_t sel);
    case (sel)
      2'd0:    pick = bus[0 +: W];
      2'd1:    pick = bus[W +: W];
      default: pick = bus[2*W +: W];
    endcase
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lanes_out[j*W +: W] = pick(lanes_in, route_src(code, j));
  end
endmodule

// File: rtl/tpp_ctrl.sv
module tpp_ctrl #(
  parameter int unsigned NSTAGE = 4,
  parameter int unsigned CFG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CFG_W-1:0]  cfg_in,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [NSTAGE-1:0] stg_vld,
  output logic              cfg_chg
);
  logic [NSTAGE-1:0] vld_nxt;

  assign cfg_chg = (cfg_in != cfg_q);

  always_comb begin
    vld_nxt[0] = in_valid;
    for (int s = 1; s < NSTAGE; s++) vld_nxt[s] = cfg_chg ? 1'b0 : stg_vld[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      stg_vld <= '0;
    end else begin
      stg_vld <= vld_nxt;
      if (cfg_chg) cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/tri_perm_pipe.sv
module tri_perm_pipe
  import tpp_pkg::*;
#(
  parameter int unsigned NSTAGE = 4,
  parameter int unsigned W      = 16,
  parameter int unsigned MUL    = 3,
  parameter int unsigned ADD    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [W-1:0]              in_sample,
  input  logic [CODE_W*NSTAGE-1:0]  cfg_in,
  input  logic [LANES*NSTAGE-1:0]   stuck_hi,
  input  logic [LANES*NSTAGE-1:0]   stuck_lo,
  output logic                      out_valid,
  output logic [W-1:0]              out_inst0,
  output logic [W-1:0]              out_inst1,
  output logic [W-1:0]              out_inst2
);
  localparam int unsigned CFG_W = CODE_W * NSTAGE;
  localparam int unsigned BUS_W = LANES * W;

  logic [CFG_W-1:0]  cfg_q;
  logic [NSTAGE-1:0] stg_vld;
  logic              cfg_chg;

  logic [BUS_W-1:0] stg_in [NSTAGE];
  logic [BUS_W-1:0] copy_q [NSTAGE];
  logic [BUS_W-1:0] routed [NSTAGE];

  tpp_ctrl #(.NSTAGE(NSTAGE), .CFG_W(CFG_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .stg_vld (stg_vld),
    .cfg_chg (cfg_chg)
  );

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign stg_in[s] = {LANES{in_sample}};
    end else begin : g_link
      assign stg_in[s] = routed[s-1];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_copy
      tpp_copy #(.W(W), .STAGE(s), .MUL(MUL), .ADD(ADD)) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (stg_in[s][j*W +: W]),
        .force_hi(stuck_hi[s*LANES + j]),
        .force_lo(stuck_lo[s*LANES + j]),
        .dout    (copy_q[s][j*W +: W])
      );
    end

    tpp_router #(.W(W)) u_route (
      .lanes_in (copy_q[s]),
      .code     (cfg_q[s*CODE_W +: CODE_W]),
      .lanes_out(routed[s])
    );
  end

  assign out_valid = stg_vld[NSTAGE-1];
  assign out_inst0 = routed[NSTAGE-1][0 +: W];
  assign out_inst1 = routed[NSTAGE-1][W +: W];
  assign out_inst2 = routed[NSTAGE-1][2*W +: W];
endmodule

// File: rtl/tpp_chk.sv
module tpp_chk #(
  parameter int unsigned NSTAGE = 4,
  parameter int unsigned W      = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [3*NSTAGE-1:0] cfg_in,
  input logic [3*NSTAGE-1:0] stuck_hi,
  input logic [3*NSTAGE-1:0] stuck_lo,
  input logic                out_valid,
  input logic [W-1:0]        out_inst0,
  input logic [W-1:0]        out_inst1,
  input logic [W-1:0]        out_inst2,
  input logic [NSTAGE-1:0]   stg_vld,
  input logic                cfg_chg
);
  localparam int unsigned CW = $clog2(NSTAGE + 1) + 1;

  logic          fault_any;
  logic [CW-1:0] clean_cnt;

  assign fault_any = (|stuck_hi) || (|stuck_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         clean_cnt <= '0;
    else if (fault_any)                 clean_cnt <= '0;
    else if (clean_cnt < CW'(NSTAGE))   clean_cnt <= clean_cnt + 1'b1;
  end

  // R9: no valid output while reset is held
  p_reset_quiet_r9: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R5: a stable vector never triggers a capture
  p_stable_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $stable(cfg_in) |-> !cfg_chg);

  // R5: capture clears every stage past the first
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (stg_vld[NSTAGE-1:1] == '0) && (stg_vld[0] == $past(in_valid)));

  // R6: valid steps forward one stage per edge
  for (genvar s = 1; s < NSTAGE; s++) begin : g_adv
    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_chg |=> stg_vld[s] == $past(stg_vld[s-1]));
  end

  // R8: fault-free history gives three equal results
  p_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fault_any && (clean_cnt >= CW'(NSTAGE)) |->
      (out_inst0 == out_inst1) && (out_inst1 == out_inst2));

  // R7: all last-stage copies stuck high drives every output high
  p_stuck_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&stuck_hi[3*NSTAGE-1 -: 3]) |->
      (&out_inst0) && (&out_inst1) && (&out_inst2));

  // R7: all last-stage copies stuck low (none high) drives every output low
  p_stuck_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&stuck_lo[3*NSTAGE-1 -: 3]) && !(|stuck_hi[3*NSTAGE-1 -: 3]) |->
      (out_inst0 == '0) && (out_inst1 == '0) && (out_inst2 == '0));
endmodule

bind tri_perm_pipe tpp_chk #(.NSTAGE(NSTAGE), .W(W)) u_chk (.*);

// File: tb/sim_tri_perm_pipe.sv
module sim_tri_perm_pipe;
  localparam int unsigned NS  = 4;
  localparam int unsigned W   = 16;
  localparam int unsigned MUL = 3;
  localparam int unsigned ADD = 5;
  localparam int unsigned CW  = 3 * NS;
  localparam int unsigned MASK = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_sample = '0;
  logic [CW-1:0] cfg_in = '0;
  logic [CW-1:0] stuck_hi = '0;
  logic [CW-1:0] stuck_lo = '0;
  logic          out_valid;
  logic [W-1:0]  out_inst0, out_inst1, out_inst2;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tri_perm_pipe #(.NSTAGE(NS), .W(W), .MUL(MUL), .ADD(ADD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_in(cfg_in), .stuck_hi(stuck_hi), .stuck_lo(stuck_lo),
    .out_valid(out_valid), .out_inst0(out_inst0), .out_inst1(out_inst1),
    .out_inst2(out_inst2)
  );

  // permutation as three decimal digits: source copy of lane 0, 1, 2
  function automatic int unsigned digits_of(int unsigned code);
    case (code)
      1: return 102;
      2: return 21;
      3: return 210;
      4: return 120;
      5: return 201;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned src_of(int unsigned code, int unsigned lane);
    int unsigned d;
    d = digits_of(code);
    if (lane == 0) return d / 100;
    if (lane == 1) return (d / 10) % 10;
    return d % 10;
  endfunction

  function automatic logic [3*W-1:0] model(logic [W-1:0] x, logic [CW-1:0] cfg,
                                           logic [CW-1:0] fhi, logic [CW-1:0] flo);
    int unsigned v[3];
    int unsigned c[3];
    for (int j = 0; j < 3; j++) v[j] = int'(x);
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < 3; j++) begin
        c[j] = (v[j] * MUL + (s + 1) * ADD) & MASK;
        if (fhi[3*s + j])      c[j] = MASK;
        else if (flo[3*s + j]) c[j] = 0;
      end
      for (int j = 0; j < 3; j++) v[j] = c[src_of(int'(cfg[3*s +: 3]), j)];
    end
    return {v[2][W-1:0], v[1][W-1:0], v[0][W-1:0]};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s out_valid: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_lanes(string tag, logic [3*W-1:0] exp);
    logic [W-1:0] act [3];
    act[0] = out_inst0; act[1] = out_inst1; act[2] = out_inst2;
    for (int j = 0; j < 3; j++) begin
      n_vec++;
      if (act[j] !== exp[j*W +: W]) begin
        n_bad++;
        $display("FAIL %s lane%0d: got %h expected %h", tag, j, act[j], exp[j*W +: W]);
      end
    end
  endtask

  // two samples under one vector/fault set, then the valid drop
  task automatic run_cfg(string tag, logic [CW-1:0] cfg, logic [CW-1:0] fhi,
                         logic [CW-1:0] flo, logic [W-1:0] x0, logic [W-1:0] x1);
    @(negedge clk);
    cfg_in = cfg; stuck_hi = fhi; stuck_lo = flo;
    in_valid = 1'b1; in_sample = x0;
    for (int k = 1; k <= NS + 1; k++) begin
      @(negedge clk);
      if (k == 1) in_sample = x1;
      if (k == 2) in_valid = 1'b0;
      if (k == NS) begin
        check_bit({tag, " R1 latency"}, out_valid, 1'b1);
        check_lanes(tag, model(x0, cfg, fhi, flo));
      end
      if (k == NS + 1) begin
        check_bit({tag, " R6 second"}, out_valid, 1'b1);
        check_lanes(tag, model(x1, cfg, fhi, flo));
      end
    end
    @(negedge clk);
    check_bit({tag, " R6 drop"}, out_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R6: got no completion expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check_bit("R9 in reset", out_valid, 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R9 after reset", out_valid, 1'b0);

    // R1, R8: fault-free, same code on every stage, lanes must agree
    for (int c = 0; c < 8; c++) begin
      logic [CW-1:0] cfg;
      for (int s = 0; s < NS; s++) cfg[3*s +: 3] = 3'(c);
      run_cfg("R1 R8 clean", cfg, '0, '0, W'(40 + 7*c), W'(16'hA5A5 ^ c));
      n_vec++;
      if (!((out_inst0 == out_inst1) && (out_inst1 == out_inst2))) begin
        n_bad++;
        $display("FAIL R8 agree: got %h/%h/%h expected equal", out_inst0, out_inst1, out_inst2);
      end
    end

    // R2, R4, R7: every routing vector, faults placed per index
    for (int i = 0; i < (1 << CW); i++) begin
      logic [CW-1:0] fhi, flo;
      fhi = CW'(1) << (i % CW);
      flo = CW'(1) << ((i / CW) % CW);
      run_cfg("R2 R4 R7 sweep", CW'(i), fhi, flo, W'(i * 97 + 5), W'(~(i * 31)));
    end

    // R3: codes 6 and 7 on every stage with a distinguishing fault
    run_cfg("R3 code6/7", 12'o6767, 12'o0004, 12'o0010, 16'h1234, 16'h0042);
    run_cfg("R3 code7/6", 12'o7676, 12'o0200, 12'o0001, 16'h7777, 16'h0003);

    // R7: both controls on all last-stage copies, ones dominate
    run_cfg("R7 priority", 12'o0000, 12'o7000, 12'o7000, 16'h0F0F, 16'h00FF);
    run_cfg("R7 low", 12'o3210, 12'o0000, 12'o7000, 16'h0F0F, 16'h00FF);

    // R5: routing change together with a new sample
    begin
      logic [CW-1:0] cfg_a, cfg_b, fhi, flo;
      cfg_a = 12'o1234; cfg_b = 12'o5050; fhi = 12'h010; flo = 12'h200;
      @(negedge clk);
      cfg_in = cfg_a; stuck_hi = fhi; stuck_lo = flo; in_valid = 1'b1;
      for (int k = 0; k < 2 * NS; k++) begin
        in_sample = W'(300 + k);
        @(negedge clk);
      end
      check_bit("R6 stream", out_valid, 1'b1);
      check_lanes("R6 stream", model(W'(300 + NS), cfg_a, fhi, flo));
      cfg_in = cfg_b; in_sample = 16'h0BAD;
      for (int k = 1; k <= NS; k++) begin
        @(negedge clk);
        if (k == 1) in_valid = 1'b0;
        if (k < NS) check_bit("R5 flush gap", out_valid, 1'b0);
        else begin
          check_bit("R5 first new", out_valid, 1'b1);
          check_lanes("R5 new routing", model(16'h0BAD, cfg_b, fhi, flo));
        end
      end
      repeat (NS + 1) @(negedge clk);
      check_bit("R5 drained", out_valid, 1'b0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule